// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns one 16-bit instruction word into a 20-bit memory address or a 16-bit immediate operand for a word-addressed processor. Bits [15:10] of the word hold the operation code, which this unit ignores. Bits [9:8] hold a 2-bit mode, and bits [7:0] hold a control byte whose meaning depends on that mode. Some modes need the word that follows the instruction. For those, the unit requests that extension word over a request/valid handshake, and it pulses a PC step strobe each time it consumes one. A separate `branch` input makes the unit take the extension word as a signed displacement from the PC.

A sequencer pulses `start` with the instruction, the PC and the index and offset register values. These are all sampled in the cycle `start` is accepted. The result appears on a one-cycle `done` pulse. The offset registers live outside the unit. When an immediate variant is chosen, the unit emits a write strobe together with the extension word, and uses that new value in the same result.

The controller has three states. IDLE waits for `start`. FETCH holds the extension-word request. RESULT presents the outputs for one cycle. The transitions are:
- LAUNCH_SHORT goes from IDLE to RESULT when the selected mode needs no extension word.
- LAUNCH_LONG goes from IDLE to FETCH when it does.
- STALL keeps FETCH while valid is low.
- ARRIVE goes from FETCH to RESULT on valid.
- RETIRE goes from RESULT back to IDLE.

Top module: `ea_unit`

## Requirements
- R1: The mode is instr[9:8] and the sub-mode is instr[7:4]. Mode 00 (register) finishes with `done` high and addr_valid, imm_valid and illegal all low, without any extension request.
- R2: Mode 01 (direct) fetches one extension word and returns it on `imm`, with imm_valid high and addr_valid low.
- R3: Mode 10 (absolute) gives addr = {instr[3:0], extension word}.
- R4: Mode 11 with sub-mode 0 (local) gives addr = {pc[19:16], extension word}.
- R5: Sub-mode 1 gives addr = pc + pc_off, with no extension word. Sub-mode 2 fetches a word E, gives addr = pc + E and raises wr_pc_off with wr_data = E. All sums wrap modulo 2^20, and 16-bit operands are zero-extended.
- R6: Sub-modes 3 and 4 give addr = zero-extended idx_y and idx_z respectively, with no extension word.
- R7: Sub-modes 5 and 7 give addr = idx + off for Y and Z respectively, with no extension word. Sub-modes 6 and 8 fetch a word E, give addr = idx + E, and raise wr_off_y or wr_off_z respectively with wr_data = E.
- R8: With `branch` high at start, one extension word D is fetched, and addr = pc + sign-extended D modulo 2^20, whatever the mode bits hold.
- R9: Mode 11 with sub-mode 9 to 15 sets illegal with `done`, requests no extension word, and gives no address or immediate.
- R10: A mode without an extension word gives `done` exactly one cycle after start. A mode with one holds ext_req from the cycle after start until ext_valid. pc_step pulses in that accepting cycle only, and `done` follows one cycle later, for one cycle.
- R11: `start` is ignored outside IDLE. The pc, index and offset inputs and the instruction are used as sampled in the accepted start cycle.
- R12: After reset, and whenever `done` is low, ext_req (outside FETCH), addr_valid, imm_valid, illegal and all write strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin address generation (accepted in IDLE only) |
| instr | input | 16 | Instruction word |
| branch | input | 1 | Treat extension word as signed branch displacement |
| pc | input | 20 | Program counter (address of the word after the instruction) |
| pc_off | input | 16 | PC offset register value |
| idx_y | input | 16 | Y index register value |
| idx_z | input | 16 | Z index register value |
| off_y | input | 16 | Y offset register value |
| off_z | input | 16 | Z offset register value |
| ext_req | output | 1 | Extension word request |
| ext_valid | input | 1 | Extension word present on ext_data |
| ext_data | input | 16 | Extension word |
| pc_step | output | 1 | Advance PC by one (extension word consumed) |
| done | output | 1 | Result valid this cycle |
| addr_valid | output | 1 | addr carries a memory address |
| addr | output | 20 | Effective address |
| imm_valid | output | 1 | imm carries an immediate operand |
| imm | output | 16 | Immediate operand |
| illegal | output | 1 | Undefined sub-mode |
| wr_pc_off | output | 1 | Write wr_data into the PC offset register |
| wr_off_y | output | 1 | Write wr_data into the Y offset register |
| wr_off_z | output | 1 | Write wr_data into the Z offset register |
| wr_data | output | 16 | Value for the offset register write |

## Verification
A wrong controller state shows at the ports within one cycle. A request can linger after valid, `done` can appear early or be missing, or `done` can arrive while a request is still open. A wrong latched kind or Y/Z choice shows on the very `done` pulse of that operation, as a wrong address, a wrong write strobe or a flag out of place. The bench changes the pc and register inputs right after start, so a path that reads them live instead of using the captured values gives a wrong address on the same pulse.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int unsigned INSTR_W  = 16;
    localparam int unsigned MODE_LSB = 8;
    localparam int unsigned SUB_LSB  = 4;

    localparam logic [1:0] MODE_REG = 2'b00;
    localparam logic [1:0] MODE_DIR = 2'b01;
    localparam logic [1:0] MODE_ABS = 2'b10;
    localparam logic [1:0] MODE_EXT = 2'b11;

    typedef enum logic [3:0] {
        K_REG, K_DIRECT, K_ABS, K_LOCAL, K_PCREL_R, K_PCREL_I,
        K_IDX, K_OFF_R, K_OFF_I, K_BRANCH, K_ILLEGAL
    } ea_kind_e;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_FETCH = 2'd1,
        S_DONE  = 2'd2
    } ea_state_e;

    typedef struct packed {
        ea_kind_e kind;
        logic     need_ext;
        logic     use_z;
    } ea_dec_t;
endpackage

// File: rtl/ea_decode.sv
module ea_decode
    import ea_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [3:0] sub,
    input  logic       branch,
    output ea_dec_t    dec
);
    always_comb begin
        dec.kind     = K_REG;
        dec.need_ext = 1'b0;
        dec.use_z    = 1'b0;
        if (branch) begin
            dec.kind     = K_BRANCH;
            dec.need_ext = 1'b1;
        end else begin
            unique case (mode)
                MODE_REG: dec.kind = K_REG;
                MODE_DIR: begin
                    dec.kind     = K_DIRECT;
                    dec.need_ext = 1'b1;
                end
                MODE_ABS: begin
                    dec.kind     = K_ABS;
                    dec.need_ext = 1'b1;
                end
                default: begin
                    unique case (sub)
                        4'd0: begin dec.kind = K_LOCAL;   dec.need_ext = 1'b1; end
                        4'd1: begin dec.kind = K_PCREL_R; end
                        4'd2: begin dec.kind = K_PCREL_I; dec.need_ext = 1'b1; end
                        4'd3: begin dec.kind = K_IDX; end
                        4'd4: begin dec.kind = K_IDX;     dec.use_z = 1'b1; end
                        4'd5: begin dec.kind = K_OFF_R; end
                        4'd6: begin dec.kind = K_OFF_I;   dec.need_ext = 1'b1; end
                        4'd7: begin dec.kind = K_OFF_R;   dec.use_z = 1'b1; end
                        4'd8: begin dec.kind = K_OFF_I;   dec.use_z = 1'b1; dec.need_ext = 1'b1; end
                        default: dec.kind = K_ILLEGAL;
                    endcase
                end
            endcase
        end
    end
endmodule

// File: rtl/ea_fsm.sv
module ea_fsm
    import ea_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic need_ext,
    input  logic ext_valid,
    output logic accept,
    output logic ext_req,
    output logic take_ext,
    output logic done
);
    ea_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = need_ext ? S_FETCH : S_DONE;
            S_FETCH: if (ext_valid) nxt = S_DONE;
            S_DONE:  nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_comb begin
        accept   = (state == S_IDLE) && start;
        ext_req  = (state == S_FETCH);
        take_ext = (state == S_FETCH) && ext_valid;
        done     = (state == S_DONE);
    end
endmodule

// File: rtl/ea_calc.sv
module ea_calc
    import ea_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned WORD_W = 16,
    localparam int unsigned PAGE_W = ADDR_W - WORD_W
) (
    input  ea_kind_e            kind,
    input  logic [PAGE_W-1:0]   page_ctl,
    input  logic [ADDR_W-1:0]   pc,
    input  logic [WORD_W-1:0]   pcoff,
    input  logic [WORD_W-1:0]   idx,
    input  logic [WORD_W-1:0]   off,
    input  logic [WORD_W-1:0]   ext,
    output logic [ADDR_W-1:0]   addr,
    output logic                addr_valid,
    output logic                imm_valid,
    output logic                illegal,
    output logic                wr_pcoff,
    output logic                wr_off
);
    logic [ADDR_W-1:0] ext_z, ext_s, pcoff_z, idx_z, off_z;

    assign ext_z   = {{PAGE_W{1'b0}}, ext};
    assign ext_s   = {{PAGE_W{ext[WORD_W-1]}}, ext};
    assign pcoff_z = {{PAGE_W{1'b0}}, pcoff};
    assign idx_z   = {{PAGE_W{1'b0}}, idx};
    assign off_z   = {{PAGE_W{1'b0}}, off};

    always_comb begin
        addr       = '0;
        addr_valid = 1'b0;
        imm_valid  = 1'b0;
        illegal    = 1'b0;
        wr_pcoff   = 1'b0;
        wr_off     = 1'b0;
        unique case (kind)
            K_REG:     ;
            K_DIRECT:  imm_valid = 1'b1;
            K_ABS:     begin addr = {page_ctl, ext};              addr_valid = 1'b1; end
            K_LOCAL:   begin addr = {pc[ADDR_W-1:WORD_W], ext};   addr_valid = 1'b1; end
            K_PCREL_R: begin addr = pc + pcoff_z;                 addr_valid = 1'b1; end
            K_PCREL_I: begin addr = pc + ext_z;  addr_valid = 1'b1; wr_pcoff = 1'b1; end
            K_IDX:     begin addr = idx_z;                        addr_valid = 1'b1; end
            K_OFF_R:   begin addr = idx_z + off_z;                addr_valid = 1'b1; end
            K_OFF_I:   begin addr = idx_z + ext_z; addr_valid = 1'b1; wr_off = 1'b1; end
            K_BRANCH:  begin addr = pc + ext_s;                   addr_valid = 1'b1; end
            default:   illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/ea_unit.sv
module ea_unit
    import ea_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [INSTR_W-1:0] instr,
    input  logic              branch,
    input  logic [ADDR_W-1:0] pc,
    input  logic [WORD_W-1:0] pc_off,
    input  logic [WORD_W-1:0] idx_y,
    input  logic [WORD_W-1:0] idx_z,
    input  logic [WORD_W-1:0] off_y,
    input  logic [WORD_W-1:0] off_z,
    output logic              ext_req,
    input  logic              ext_valid,
    input  logic [WORD_W-1:0] ext_data,
    output logic              pc_step,
    output logic              done,
    output logic              addr_valid,
    output logic [ADDR_W-1:0] addr,
    output logic              imm_valid,
    output logic [WORD_W-1:0] imm,
    output logic              illegal,
    output logic              wr_pc_off,
    output logic              wr_off_y,
    output logic              wr_off_z,
    output logic [WORD_W-1:0] wr_data
);
    localparam int unsigned PAGE_W = ADDR_W - WORD_W;

    ea_dec_t dec;
    logic    accept, take_ext;
    logic    unused_opcode;

    ea_kind_e          kind_q;
    logic              use_z_q;
    logic [PAGE_W-1:0] page_q;
    logic [ADDR_W-1:0] pc_q;
    logic [WORD_W-1:0] pcoff_q, idx_q, off_q, ext_q;

    logic [ADDR_W-1:0] c_addr;
    logic c_av, c_iv, c_ill, c_wpc, c_woff;

    assign unused_opcode = ^instr[INSTR_W-1:MODE_LSB+2];

    ea_decode u_dec (
        .mode   (instr[MODE_LSB+1:MODE_LSB]),
        .sub    (instr[SUB_LSB+3:SUB_LSB]),
        .branch (branch),
        .dec    (dec)
    );

    ea_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .need_ext  (dec.need_ext),
        .ext_valid (ext_valid),
        .accept    (accept),
        .ext_req   (ext_req),
        .take_ext  (take_ext),
        .done      (done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_REG;
            use_z_q <= 1'b0;
            page_q  <= '0;
            pc_q    <= '0;
            pcoff_q <= '0;
            idx_q   <= '0;
            off_q   <= '0;
            ext_q   <= '0;
        end else begin
            if (accept) begin
                kind_q  <= dec.kind;
                use_z_q <= dec.use_z;
                page_q  <= instr[PAGE_W-1:0];
                pc_q    <= pc;
                pcoff_q <= pc_off;
                idx_q   <= dec.use_z ? idx_z : idx_y;
                off_q   <= dec.use_z ? off_z : off_y;
            end
            if (take_ext) ext_q <= ext_data;
        end
    end

    ea_calc #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_calc (
        .kind       (kind_q),
        .page_ctl   (page_q),
        .pc         (pc_q),
        .pcoff      (pcoff_q),
        .idx        (idx_q),
        .off        (off_q),
        .ext        (ext_q),
        .addr       (c_addr),
        .addr_valid (c_av),
        .imm_valid  (c_iv),
        .illegal    (c_ill),
        .wr_pcoff   (c_wpc),
        .wr_off     (c_woff)
    );

    assign pc_step    = take_ext;
    assign addr_valid = done & c_av;
    assign addr       = (done & c_av) ? c_addr : '0;
    assign imm_valid  = done & c_iv;
    assign imm        = (done & c_iv) ? ext_q : '0;
    assign illegal    = done & c_ill;
    assign wr_pc_off  = done & c_wpc;
    assign wr_off_y   = done & c_woff & ~use_z_q;
    assign wr_off_z   = done & c_woff & use_z_q;
    assign wr_data    = (done & (c_wpc | c_woff)) ? ext_q : '0;
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_req,
    input logic ext_valid,
    input logic pc_step,
    input logic done,
    input logic addr_valid,
    input logic imm_valid,
    input logic illegal,
    input logic wr_pc_off,
    input logic wr_off_y,
    input logic wr_off_z
);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_valid) |=> ext_req);

    a_r10_arrive_done: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && ext_valid) |=> (done && !ext_req));

    a_r10_step_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        pc_step |=> done);

    a_r1_one_result: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({addr_valid, imm_valid, illegal}));

    a_r9_illegal_short: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !$past(ext_req));

    a_r7_one_write: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_pc_off, wr_off_y, wr_off_z}));

    a_r5_write_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pc_off || wr_off_y || wr_off_z) |-> (addr_valid && $past(ext_req)));

    a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> !(addr_valid || imm_valid || illegal || wr_pc_off || wr_off_y || wr_off_z));
endmodule

bind ea_unit ea_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_req    (ext_req),
    .ext_valid  (ext_valid),
    .pc_step    (pc_step),
    .done       (done),
    .addr_valid (addr_valid),
    .imm_valid  (imm_valid),
    .illegal    (illegal),
    .wr_pc_off  (wr_pc_off),
    .wr_off_y   (wr_off_y),
    .wr_off_z   (wr_off_z)
);

// File: tb/ea_unit_tb.sv
`timescale 1ns/1ps
module ea_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic        branch = 1'b0;
    logic [19:0] pc = '0;
    logic [15:0] pc_off = '0, idx_y = '0, idx_z = '0, off_y = '0, off_z = '0;
    logic        ext_valid = 1'b0;
    logic [15:0] ext_data = '0;
    logic        ext_req, pc_step, done, addr_valid, imm_valid, illegal;
    logic        wr_pc_off, wr_off_y, wr_off_z;
    logic [19:0] addr;
    logic [15:0] imm, wr_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ea_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .branch(branch),
        .pc(pc), .pc_off(pc_off), .idx_y(idx_y), .idx_z(idx_z), .off_y(off_y),
        .off_z(off_z), .ext_req(ext_req), .ext_valid(ext_valid), .ext_data(ext_data),
        .pc_step(pc_step), .done(done), .addr_valid(addr_valid), .addr(addr),
        .imm_valid(imm_valid), .imm(imm), .illegal(illegal), .wr_pc_off(wr_pc_off),
        .wr_off_y(wr_off_y), .wr_off_z(wr_off_z), .wr_data(wr_data)
    );

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", what, act, exp);
        end
    endtask

    // Reference model built from the requirements.
    task automatic ref_op(input logic [15:0] ins, input bit br, input logic [19:0] p,
                          input logic [15:0] pco, iy, iz, oy, oz, ext,
                          output bit need, output bit av, output logic [19:0] ea,
                          output bit iv, output bit ill, output bit wp, output bit wy,
                          output bit wz, output string tag);
        logic [1:0] md = ins[9:8];
        logic [3:0] sb = ins[7:4];
        need = 0; av = 0; ea = '0; iv = 0; ill = 0; wp = 0; wy = 0; wz = 0;
        if (br) begin
            need = 1; av = 1; ea = p + {{4{ext[15]}}, ext}; tag = "R8";
        end else if (md == 2'b00) begin
            tag = "R1";
        end else if (md == 2'b01) begin
            need = 1; iv = 1; tag = "R2";
        end else if (md == 2'b10) begin
            need = 1; av = 1; ea = {ins[3:0], ext}; tag = "R3";
        end else begin
            case (sb)
                4'd0: begin need = 1; av = 1; ea = {p[19:16], ext}; tag = "R4"; end
                4'd1: begin av = 1; ea = p + {4'h0, pco}; tag = "R5"; end
                4'd2: begin need = 1; av = 1; ea = p + {4'h0, ext}; wp = 1; tag = "R5"; end
                4'd3: begin av = 1; ea = {4'h0, iy}; tag = "R6"; end
                4'd4: begin av = 1; ea = {4'h0, iz}; tag = "R6"; end
                4'd5: begin av = 1; ea = {4'h0, iy} + {4'h0, oy}; tag = "R7"; end
                4'd6: begin need = 1; av = 1; ea = {4'h0, iy} + {4'h0, ext}; wy = 1; tag = "R7"; end
                4'd7: begin av = 1; ea = {4'h0, iz} + {4'h0, oz}; tag = "R7"; end
                4'd8: begin need = 1; av = 1; ea = {4'h0, iz} + {4'h0, ext}; wz = 1; tag = "R7"; end
                default: begin ill = 1; tag = "R9"; end
            endcase
        end
    endtask

    task automatic run_op(input logic [15:0] ins, input bit br, input logic [15:0] ext,
                          input int lat, input bit poke);
        bit need, av, iv, ill, wp, wy, wz;
        logic [19:0] ea;
        string tag;
        ref_op(ins, br, pc, pc_off, idx_y, idx_z, off_y, off_z, ext,
               need, av, ea, iv, ill, wp, wy, wz, tag);
        @(negedge clk);
        start = 1'b1; instr = ins; branch = br;
        @(negedge clk);
        start = 1'b0;
        // R11: operands must have been captured; scramble the live inputs.
        instr = 16'($urandom); branch = 1'($urandom);
        pc = 20'($urandom); pc_off = 16'($urandom);
        idx_y = 16'($urandom); idx_z = 16'($urandom);
        off_y = 16'($urandom); off_z = 16'($urandom);
        if (need) begin
            chk({tag, " R10 ext_req after start"}, ext_req, 1);
            chk({tag, " R10 no done while fetching"}, done, 0);
            for (int i = 0; i < lat; i++) begin
                if (poke) start = 1'b1;
                @(negedge clk);
                chk({tag, " R10 ext_req held"}, ext_req, 1);
            end
            start = 1'b0;
            ext_valid = 1'b1; ext_data = ext;
            #1;
            chk({tag, " R10 pc_step on accept"}, pc_step, 1);
            @(negedge clk);
            ext_valid = 1'b0; ext_data = 16'($urandom);
            chk({tag, " R10 pc_step single"}, pc_step, 0);
        end else begin
            chk({tag, " R10 no ext_req"}, ext_req, 0);
        end
        chk({tag, " R10 done"}, done, 1);
        chk({tag, " addr_valid"}, addr_valid, av);
        if (av) chk({tag, " addr"}, addr, ea);
        chk({tag, " imm_valid"}, imm_valid, iv);
        if (iv) chk({tag, " imm"}, imm, ext);
        chk({tag, " illegal"}, illegal, ill);
        chk({tag, " write strobes"}, {wr_pc_off, wr_off_y, wr_off_z}, {wp, wy, wz});
        if (wp || wy || wz) chk({tag, " wr_data"}, wr_data, ext);
        if (poke) start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R11 back to idle, done low"}, done, 0);
        chk({tag, " R11 no request after retire"}, ext_req, 0);
        chk({tag, " R12 outputs quiet"}, {addr_valid, imm_valid, illegal}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        chk("R12 reset ext_req", ext_req, 0);
        chk("R12 reset done", done, 0);
        chk("R12 reset flags", {addr_valid, imm_valid, illegal, wr_pc_off, wr_off_y, wr_off_z}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 idle after reset", {ext_req, done}, 0);

        // Directed corner cases
        run_op(16'hFC12, 0, 16'h0000, 0, 0);                       // R1 register
        run_op(16'h0100, 0, 16'h1234, 2, 0);                       // R2 direct
        run_op(16'h02A7, 0, 16'hBEEF, 0, 0);                       // R3 absolute
        pc = 20'h31234;
        run_op(16'h0300, 0, 16'h0042, 1, 0);                       // R4 local
        pc = 20'hFFFF0; pc_off = 16'h0020;
        run_op(16'h0310, 0, 16'h0000, 0, 0);                       // R5 wrap
        pc = 20'h12345;
        run_op(16'h0320, 0, 16'h0100, 0, 0);                       // R5 immediate
        idx_y = 16'hABCD; idx_z = 16'h1357;
        run_op(16'h0330, 0, 16'h0000, 0, 0);                       // R6 Y
        idx_y = 16'hABCD; idx_z = 16'h1357;
        run_op(16'h0340, 0, 16'h0000, 0, 0);                       // R6 Z
        idx_y = 16'hFFFF; off_y = 16'h0002;
        run_op(16'h0350, 0, 16'h0000, 0, 0);                       // R7 carry past 16 bits
        idx_z = 16'hF000;
        run_op(16'h0380, 0, 16'h2000, 3, 0);                       // R7 Z immediate
        pc = 20'h00005;
        run_op(16'h0000, 1, 16'hFFF0, 0, 0);                       // R8 negative wrap
        run_op(16'h0390, 0, 16'h0000, 0, 0);                       // R9 low illegal
        run_op(16'h03F0, 0, 16'h0000, 0, 1);                       // R9 high illegal, R11 poke
        run_op(16'h0160, 0, 16'h5A5A, 3, 1);                       // R11 start during fetch

        // Constrained random
        for (int n = 0; n < 400; n++) begin
            logic [15:0] ins;
            ins = 16'($urandom);
            if ($urandom % 2 == 0) ins[9:8] = 2'b11;
            if (ins[9:8] == 2'b11 && $urandom % 3 != 0) ins[7:4] = 4'($urandom % 9);
            pc = 20'($urandom); pc_off = 16'($urandom);
            idx_y = 16'($urandom); idx_z = 16'($urandom);
            off_y = 16'($urandom); off_z = 16'($urandom);
            run_op(ins, ($urandom % 8 == 0), 16'($urandom), int'($urandom % 4),
                   ($urandom % 5 == 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule